// File: doc/BRIEF.md
# Immediate Extension and ALU Execute Stage

This block is the combinational execute step of a small 32-bit load-store processor core. It receives one fixed-width 32-bit instruction word together with the two source operand values already read from the register file. It pulls the instruction apart into its fields and widens the 16-bit constant to full data width, sign-filled or zero-filled as the opcode demands. It then computes the ALU result and reports which register index should receive that result and whether a write should happen at all.

Two layouts are decoded. When the 6-bit opcode in bits 31:26 is zero, the word is a register-form instruction. In that form rs sits in bits 25:21, rt in 20:16, rd in 15:11, the shift amount in 10:6 and the function code in 5:0, and the result targets rd. Any other opcode is an immediate-form instruction: rs in 25:21, rt in 20:16, the constant in 15:0, and the result targets rt. The register file, memory access and program counter sit outside this block. The operand values arrive on `rs_val_i` (the register named by bits 25:21) and `rt_val_i` (the register named by bits 20:16).

Top module: `exec_stage`

## Requirements
- R1: Opcode 0x08 yields rs_val + the constant sign-extended from bit 15, wrapping modulo 2^32, with destination rt and write enable high.
- R2: Opcode 0x09 yields rs_val + the constant zero-extended to 32 bits, with destination rt.
- R3: Opcode 0x0D yields rs_val bitwise-OR the zero-extended constant, with destination rt.
- R4: Opcode 0x0F yields the constant in bits 31:16 and zeros in bits 15:0, whatever rs_val holds, with destination rt.
- R5: Opcode 0 with function code 34 yields rs_val - rt_val, with destination rd (bits 15:11).
- R6: Opcode 0 with function code 42 yields 1 when rs_val < rt_val as two's-complement numbers and 0 otherwise, with destination rd.
- R7: Opcode 0 with function code 43 yields 1 when rs_val < rt_val as unsigned numbers and 0 otherwise, with destination rd.
- R8: Opcode 0 with function code 0 yields rt_val shifted left by the amount in bits 10:6, zero-filled, with destination rd.
- R9: Any other opcode, or opcode 0 with any other function code, drives write enable low and the result to zero. The destination still follows the format: rd when the opcode is 0, rt otherwise.
- R10: Whenever the destination index is 0, write enable is low, while the result is still computed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word under execution |
| rs_val_i | input | 32 | Value of the register named in bits 25:21 |
| rt_val_i | input | 32 | Value of the register named in bits 20:16 |
| result_o | output | 32 | ALU result |
| dest_o | output | 5 | Register index to be written |
| wr_en_o | output | 1 | High when the result should be written back |

## Verification
The bench instantiates the block with its default parameters: a 32-bit datapath and 5-bit register indices. That width is what makes the 16-bit constant's bit 15 the sign bit, and it puts signed and unsigned comparison apart on operands such as 0xFFFFFFFF against 1. A maximum shift of 31 moves a single bit into the top position. The defaults also bring carry wrap at 0x7FFFFFFF + 1, constants with bit 15 set under both extension modes, and writes aimed at register 0 in both formats within reach.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int unsigned INSN_W  = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FUNC_W  = 6;
  localparam int unsigned IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  localparam logic [FUNC_W-1:0] FN_SLL  = 6'd0;
  localparam logic [FUNC_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FUNC_W-1:0] FN_SLT  = 6'd42;
  localparam logic [FUNC_W-1:0] FN_SLTU = 6'd43;

  typedef enum logic [2:0] {
    ALU_NONE,
    ALU_ADD,
    ALU_OR,
    ALU_HIGH,
    ALU_SUB,
    ALU_LTS,
    ALU_LTU,
    ALU_SHL
  } alu_op_e;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
#(
  parameter int unsigned RIDX_W = 5,
  localparam int unsigned SH_W  = 5
) (
  input  logic [INSN_W-1:0] insn_i,
  output alu_op_e           op_o,
  output logic              use_imm_o,
  output logic              imm_signed_o,
  output logic [SH_W-1:0]   shamt_o,
  output logic [RIDX_W-1:0] dest_o,
  output logic              wr_en_o
);

  logic [OPC_W-1:0]  opcode;
  logic [FUNC_W-1:0] funct;
  logic [RIDX_W-1:0] rt_idx;
  logic [RIDX_W-1:0] rd_idx;
  logic              reg_form;
  logic              known;

  assign opcode   = insn_i[INSN_W-1 -: OPC_W];
  assign funct    = insn_i[FUNC_W-1:0];
  assign rt_idx   = insn_i[IMM_W +: RIDX_W];
  assign rd_idx   = insn_i[IMM_W-RIDX_W +: RIDX_W];
  assign shamt_o  = insn_i[FUNC_W +: SH_W];
  assign reg_form = (opcode == OPC_REG);

  always_comb begin
    op_o         = ALU_NONE;
    use_imm_o    = !reg_form;
    imm_signed_o = 1'b0;
    known        = 1'b0;
    if (reg_form) begin
      unique case (funct)
        FN_SUB:  begin op_o = ALU_SUB; known = 1'b1; end
        FN_SLT:  begin op_o = ALU_LTS; known = 1'b1; end
        FN_SLTU: begin op_o = ALU_LTU; known = 1'b1; end
        FN_SLL:  begin op_o = ALU_SHL; known = 1'b1; end
        default: begin op_o = ALU_NONE; known = 1'b0; end
      endcase
    end else begin
      unique case (opcode)
        OPC_ADDI:  begin op_o = ALU_ADD;  imm_signed_o = 1'b1; known = 1'b1; end
        OPC_ADDIU: begin op_o = ALU_ADD;  known = 1'b1; end
        OPC_ORI:   begin op_o = ALU_OR;   known = 1'b1; end
        OPC_LUI:   begin op_o = ALU_HIGH; known = 1'b1; end
        default:   begin op_o = ALU_NONE; known = 1'b0; end
      endcase
    end
  end

  assign dest_o  = reg_form ? rd_idx : rt_idx;
  assign wr_en_o = known && (dest_o != '0);

endmodule

// File: rtl/exec_immext.sv
module exec_immext
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             signed_i,
  output logic [XLEN-1:0]  ext_o
);

  localparam int unsigned FILL_W = XLEN - IMM_W;

  logic fill_bit;
  assign fill_bit = signed_i & imm_i[IMM_W-1];
  assign ext_o    = {{FILL_W{fill_bit}}, imm_i};

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SH_W = $clog2(XLEN)
) (
  input  alu_op_e          op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [XLEN-1:0]  y_o
);

  logic [XLEN-1:0] diff;
  logic            lt_u;
  logic            lt_s;

  assign diff = a_i - b_i;
  assign lt_u = (a_i < b_i);
  assign lt_s = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : lt_u;

  always_comb begin
    unique case (op_i)
      ALU_ADD:  y_o = a_i + b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_HIGH: y_o = b_i << IMM_W;
      ALU_SUB:  y_o = diff;
      ALU_LTS:  y_o = {{(XLEN-1){1'b0}}, lt_s};
      ALU_LTU:  y_o = {{(XLEN-1){1'b0}}, lt_u};
      ALU_SHL:  y_o = b_i << shamt_i;
      default:  y_o = '0;
    endcase
  end

endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic [XLEN-1:0]   result_o,
  output logic [RIDX_W-1:0] dest_o,
  output logic              wr_en_o
);

  localparam int unsigned SH_W = $clog2(XLEN);

  alu_op_e         alu_op;
  logic            use_imm;
  logic            imm_signed;
  logic [SH_W-1:0] shamt;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] operand_b;
  logic            unused_rs_idx;

  assign unused_rs_idx = ^insn_i[IMM_W+RIDX_W +: RIDX_W];

  exec_decode #(.RIDX_W(RIDX_W)) u_dec (
    .insn_i       (insn_i),
    .op_o         (alu_op),
    .use_imm_o    (use_imm),
    .imm_signed_o (imm_signed),
    .shamt_o      (shamt),
    .dest_o       (dest_o),
    .wr_en_o      (wr_en_o)
  );

  exec_immext #(.XLEN(XLEN)) u_ext (
    .imm_i    (insn_i[IMM_W-1:0]),
    .signed_i (imm_signed),
    .ext_o    (imm_ext)
  );

  assign operand_b = use_imm ? imm_ext : rt_val_i;

  exec_alu #(.XLEN(XLEN)) u_alu (
    .op_i    (alu_op),
    .a_i     (rs_val_i),
    .b_i     (operand_b),
    .shamt_i (shamt),
    .y_o     (result_o)
  );

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk
  import exec_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RIDX_W = 5
) (
  input logic [INSN_W-1:0] insn_i,
  input logic [XLEN-1:0]   rs_val_i,
  input logic [XLEN-1:0]   rt_val_i,
  input logic [XLEN-1:0]   result_o,
  input logic [RIDX_W-1:0] dest_o,
  input logic              wr_en_o
);

  logic [OPC_W-1:0]  c_opc;
  logic [FUNC_W-1:0] c_fn;
  logic              c_valid;

  assign c_opc   = insn_i[INSN_W-1 -: OPC_W];
  assign c_fn    = insn_i[FUNC_W-1:0];
  assign c_valid = !$isunknown({insn_i, rs_val_i, rt_val_i});

  always_comb begin
    if (c_valid) begin
      assert_no_zero_write_R10: assert (!(dest_o == '0 && wr_en_o));
      assert_unknown_silent_R9: assert (!(c_opc != OPC_REG && c_opc != OPC_ADDI &&
                                          c_opc != OPC_ADDIU && c_opc != OPC_ORI &&
                                          c_opc != OPC_LUI) || (!wr_en_o && result_o == '0));
      assert_high_clear_R4: assert (c_opc != OPC_LUI || result_o[IMM_W-1:0] == '0);
      assert_imm_dest_R1: assert (c_opc == OPC_REG || dest_o == insn_i[IMM_W +: RIDX_W]);
      assert_sub_inverse_R5: assert (!(c_opc == OPC_REG && c_fn == FN_SUB) ||
                                     (result_o + rt_val_i == rs_val_i));
      assert_flag_width_R6: assert (!(c_opc == OPC_REG && (c_fn == FN_SLT || c_fn == FN_SLTU)) ||
                                    result_o[XLEN-1:1] == '0);
    end
  end

endmodule

bind exec_stage exec_stage_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .insn_i   (insn_i),
  .rs_val_i (rs_val_i),
  .rt_val_i (rt_val_i),
  .result_o (result_o),
  .dest_o   (dest_o),
  .wr_en_o  (wr_en_o)
);

// File: tb/sim_exec_stage.sv
module sim_exec_stage;

  localparam int NV = 18;
  localparam int VW = 4 + 32*4 + 5 + 1;

  // {req, insn, rs_val, rt_val, exp_result, exp_dest, exp_we}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd1,  32'h20E4004E, 32'd100,        32'd0,        32'h000000B2, 5'd4,  1'b1}, // R1 positive constant
    {4'd1,  32'h20A2FFFF, 32'd10,         32'd0,        32'd9,        5'd2,  1'b1}, // R1 negative constant
    {4'd1,  32'h20A20001, 32'h7FFFFFFF,   32'd0,        32'h80000000, 5'd2,  1'b1}, // R1 wrap
    {4'd2,  32'h24238000, 32'h00000010,   32'd0,        32'h00008010, 5'd3,  1'b1}, // R2 zero fill
    {4'd3,  32'h35088567, 32'h12340000,   32'd0,        32'h12348567, 5'd8,  1'b1}, // R3
    {4'd4,  32'h3C091B23, 32'hFFFFFFFF,   32'd0,        32'h1B230000, 5'd9,  1'b1}, // R4
    {4'd5,  32'h01093822, 32'd50,         32'd80,       32'hFFFFFFE2, 5'd7,  1'b1}, // R5
    {4'd6,  32'h0064282A, 32'hFFFFFFFF,   32'd1,        32'd1,        5'd5,  1'b1}, // R6 -1 < 1
    {4'd6,  32'h0064282A, 32'd7,          32'd7,        32'd0,        5'd5,  1'b1}, // R6 equal
    {4'd7,  32'h0064282B, 32'hFFFFFFFF,   32'd1,        32'd0,        5'd5,  1'b1}, // R7 big vs 1
    {4'd7,  32'h0064282B, 32'd1,          32'hFFFFFFFF, 32'd1,        5'd5,  1'b1}, // R7
    {4'd8,  32'h00095100, 32'd0,          32'h000000F1, 32'h00000F10, 5'd10, 1'b1}, // R8 by 4
    {4'd8,  32'h000957C0, 32'd0,          32'd3,        32'h80000000, 5'd10, 1'b1}, // R8 by 31
    {4'd8,  32'h00095000, 32'd0,          32'h0000ABCD, 32'h0000ABCD, 5'd10, 1'b1}, // R8 by 0
    {4'd9,  32'h8C040008, 32'd5,          32'd6,        32'd0,        5'd4,  1'b0}, // R9 opcode
    {4'd9,  32'h00642820, 32'd5,          32'd6,        32'd0,        5'd5,  1'b0}, // R9 funct
    {4'd10, 32'h20E00005, 32'd1,          32'd0,        32'd6,        5'd0,  1'b0}, // R10 imm form
    {4'd10, 32'h01090022, 32'd5,          32'd3,        32'd2,        5'd0,  1'b0}  // R10 reg form
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] insn;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en;

  int n_cmp;
  int n_bad;
  bit done;

  exec_stage u0 (
    .insn_i   (insn),
    .rs_val_i (rs_val),
    .rt_val_i (rt_val),
    .result_o (result),
    .dest_o   (dest),
    .wr_en_o  (wr_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic drive(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    #1;
    insn   = i;
    rs_val = a;
    rt_val = b;
    @(negedge clk);
  endtask

  task automatic cmp(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    n_cmp  = 0;
    n_bad  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    insn   = '0;
    rs_val = '0;
    rt_val = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // Reset state: all-zero word is a shift into r0; R10 no write, R8 zero result
    cmp(10, "reset wr_en", {31'd0, wr_en}, 32'd0);
    cmp(8,  "reset result", result, 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      drive(v[VW-5 -: 32], v[VW-37 -: 32], v[VW-69 -: 32]);
      cmp(int'(v[VW-1 -: 4]), "result", result, v[37:6]);
      cmp(int'(v[VW-1 -: 4]), "dest", {27'd0, dest}, {27'd0, v[5:1]});
      cmp(int'(v[VW-1 -: 4]), "wr_en", {31'd0, wr_en}, {31'd0, v[0]});
    end

    // R4: rs_val must not affect the upper-constant load
    for (int k = 0; k < 3; k++) begin
      drive(32'h3C09BEEF, 32'h13579BDF * k, 32'h2468ACE0);
      cmp(4, "ignore rs", result, 32'hBEEF0000);
    end

    // R2 vs R1: same constant 0xFFFF under both extensions
    drive(32'h2422FFFF, 32'd1, 32'd0);
    cmp(2, "zero ext", result, 32'h00010000);
    drive(32'h2022FFFF, 32'd1, 32'd0);
    cmp(1, "sign ext", result, 32'd0);

    // R3: constant with bit 15 set is not sign-filled
    drive(32'h3508F000, 32'd0, 32'd0);
    cmp(3, "or zero fill", result, 32'h0000F000);

    // R6: most negative against most positive
    drive(32'h0064282A, 32'h80000000, 32'h7FFFFFFF);
    cmp(6, "slt extremes", result, 32'd1);

    // R9: unknown opcode with rt = 0 still reports rt and stays silent
    drive(32'hFC00FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    cmp(9, "unknown result", result, 32'd0);
    cmp(9, "unknown wr_en", {31'd0, wr_en}, 32'd0);

    done = 1'b1;
    finish_run();
  end

endmodule